// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block is the host-facing register port of a small peripheral. The host processor shares eight wires between address and data. A falling address-latch strobe marks the moment the host presents a register address and its chip-select level. Afterwards, separate active-low read and write strobes move data to or from the addressed register. A read or write only takes effect if the select captured at that latch event was active. Bus drive is shown as a data output paired with an output enable, not as a tri-state pad.

The block holds two control registers, a tone register and a read-only detect register. Single-cycle pulses on a detect input set bits in the detect register. Any new detect pulse pulls an active-low interrupt low. The interrupt stays low until the host finishes reading the detect register, and that completed read also clears the flags. One control bit selects the source of an output clock: the crystal frequency, or a baud clock at sixteen times the data rate. All three strobes come from outside the clock domain. Each strobe passes through a two-flop synchronizer, and edges are detected from the synchronized values.

Top module: `mbus_regif`

## Requirements
- R1: On a falling edge of `ale_i`, the block captures `ad_i[2:0]` as the register address and `cs_n_i` as the select. Bits `ad_i[7:3]` are ignored. After the capture, `cs_n_i` may change with no effect until the next falling edge of `ale_i`.
- R2: If the captured select was high (inactive), `ad_oe_o` stays 0 during reads. Write strobes also leave every register unchanged.
- R3: `ad_oe_o` is 1 only while the synchronized read strobe is low and the captured select is active. While `ad_oe_o` is 1, `ad_o` carries the addressed register.
- R4: A write commits `ad_i` into the addressed register on the rising edge of `wr_n_i`. Address 0 is control register A (`ctl0_o`), address 1 is control register B (`ctl1_o`) and address 3 is the tone register (`tone_o`). Writes to address 2 and to addresses 4 to 7 change nothing.
- R5: A read returns `ctl0_o` at address 0, `ctl1_o` at address 1, the detect flags (zero-extended) at address 2 and `tone_o` at address 3. Addresses 4 to 7 read as zero.
- R6: Each high bit of `det_pulse_i` sets the matching detect flag, which stays set. `irq_n_o` is 0 on the cycle after any pulse.
- R7: `irq_n_o` stays 0 until a read of address 2 ends, marked by the rising edge of `rd_n_i`. At that edge, all flags clear and `irq_n_o` returns to 1. Reads of other addresses leave flags and interrupt alone.
- R8: If a detect pulse arrives in the same cycle that a completed detect read clears the flags, the flags afterwards hold exactly that pulse's bits, and `irq_n_o` stays 0.
- R9: Reset (`rst` high) has these effects:
  - `ctl0_o`, `ctl1_o`, `tone_o` and all detect flags clear to 0.
  - `irq_n_o` goes to 1 and `clk_sel_o` goes to 0.
  - The captured select becomes inactive.
- R10: `clk_sel_o` follows bit 7 of control register B. The value 0 selects the crystal-frequency clock; 1 selects the baud clock at sixteen times the data rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address-latch strobe; capture on falling edge |
| cs_n_i | input | 1 | Chip select, active low, captured with the address |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; commit on rising edge |
| ad_i | input | 8 | Address/data bus as seen by the block |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe_o | output | 1 | Bus drive enable for `ad_o` |
| det_pulse_i | input | 8 | Per-bit detect event pulses |
| irq_n_o | output | 1 | Interrupt, active low (low = asserted, high = released) |
| ctl0_o | output | 8 | Control register A |
| ctl1_o | output | 8 | Control register B |
| tone_o | output | 8 | Tone register |
| clk_sel_o | output | 1 | Output clock select: 0 crystal, 1 baud x16 |

## Verification
A detect pulse and the flag clear caused by a completed detect-register read can land on the same clock edge. In that case the new event must survive while every older flag is dropped. The bench counts the synchronizer stages from the rising edge of the read strobe, and places a one-cycle pulse on exactly the edge where the clear takes effect. It then reads the detect register. The read must show only the new bit, with the interrupt still low, and a second completed read must then release it.

// File: rtl/mbus_regif.sv
module mbus_regif #(
  parameter int DW         = 8,
  parameter int AW         = 3,
  parameter int DET_W      = 8,
  parameter int CLKSEL_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_i,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  input  logic [DET_W-1:0] det_pulse_i,
  output logic          irq_n_o,
  output logic [DW-1:0] ctl0_o,
  output logic [DW-1:0] ctl1_o,
  output logic [DW-1:0] tone_o,
  output logic          clk_sel_o
);

  localparam logic [AW-1:0] A_CTL0 = AW'(0);
  localparam logic [AW-1:0] A_CTL1 = AW'(1);
  localparam logic [AW-1:0] A_DET  = AW'(2);
  localparam logic [AW-1:0] A_TONE = AW'(3);
  localparam logic [2:0]    IDLE   = 3'b110;

  logic [2:0] s1, s2, s3;
  logic [AW-1:0] addr_q;
  logic sel_q;
  logic [DET_W-1:0] flags_q;
  logic irq_q;
  logic [DW-1:0] c0_q, c1_q, tn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= {wr_n_i, rd_n_i, ale_i};
      s2 <= s1;
      s3 <= s2;
    end
  end

  wire ale_fall = s3[0] & ~s2[0];
  wire rd_rise  = s2[1] & ~s3[1];
  wire wr_rise  = s2[2] & ~s3[2];
  wire rd_act   = ~s2[1];
  wire wr_en    = wr_rise & sel_q;
  wire det_clr  = rd_rise & sel_q & (addr_q == A_DET);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else if (ale_fall) begin
      addr_q <= ad_i[AW-1:0];
      sel_q  <= ~cs_n_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_q <= '0;
      c1_q <= '0;
      tn_q <= '0;
    end else if (wr_en) begin
      if (addr_q == A_CTL0) c0_q <= ad_i;
      if (addr_q == A_CTL1) c1_q <= ad_i;
      if (addr_q == A_TONE) tn_q <= ad_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (det_clr ? '0 : flags_q) | det_pulse_i;
      irq_q   <= (det_clr ? 1'b0 : irq_q) | (|det_pulse_i);
    end
  end

  always_comb begin
    case (addr_q)
      A_CTL0:  ad_o = c0_q;
      A_CTL1:  ad_o = c1_q;
      A_DET:   ad_o = DW'(flags_q);
      A_TONE:  ad_o = tn_q;
      default: ad_o = '0;
    endcase
  end

  assign ad_oe_o   = rd_act & sel_q;
  assign irq_n_o   = ~irq_q;
  assign ctl0_o    = c0_q;
  assign ctl1_o    = c1_q;
  assign tone_o    = tn_q;
  assign clk_sel_o = c1_q[CLKSEL_BIT];

endmodule

module mbus_regif_chk #(
  parameter int DW    = 8,
  parameter int DET_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_q,
  input logic          det_clr,
  input logic          ad_oe_o,
  input logic          irq_n_o,
  input logic [DET_W-1:0] det_pulse_i,
  input logic [DW-1:0] ctl0_o,
  input logic [DW-1:0] ctl1_o,
  input logic [DW-1:0] tone_o
);
  // R3
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe_o |-> sel_q);
  // R2
  nosel_regs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> $stable({ctl0_o, ctl1_o, tone_o}));
  // R6
  irq_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|det_pulse_i) |=> !irq_n_o);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o && !det_clr) |=> !irq_n_o);
  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (det_clr && det_pulse_i == '0) |=> irq_n_o);
endmodule

bind mbus_regif mbus_regif_chk #(.DW(DW), .DET_W(DET_W)) u_chk (
  .clk(clk), .rst(rst), .sel_q(sel_q), .det_clr(det_clr),
  .ad_oe_o(ad_oe_o), .irq_n_o(irq_n_o), .det_pulse_i(det_pulse_i),
  .ctl0_o(ctl0_o), .ctl1_o(ctl1_o), .tone_o(tone_o)
);

// File: tb/test_mbus_regif.sv
module test_mbus_regif;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] det = 8'h00;
  logic [7:0] ad_out, c0, c1, tn;
  logic oe, irq_n, csel;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbus_regif i_mbus_regif (
    .clk(clk), .rst(rst), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
    .wr_n_i(wr_n), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(oe),
    .det_pulse_i(det), .irq_n_o(irq_n), .ctl0_o(c0), .ctl1_o(c1),
    .tone_o(tn), .clk_sel_o(csel)
  );

  // {addr[2:0], write data, expected read}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'h5A, 8'h5A},
    {3'd1, 8'h3C, 8'h3C},
    {3'd3, 8'hA5, 8'hA5},
    {3'd2, 8'hFF, 8'h00},
    {3'd5, 8'h77, 8'h00},
    {3'd0, 8'h00, 8'h00},
    {3'd1, 8'h81, 8'h81},
    {3'd7, 8'h11, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [2:0] a, input logic csn);
    ad_in = {5'b10101, a};
    cs_n = csn;
    ale = 1'b1;
    waitn(2);
    ale = 1'b0;
    waitn(4);
    cs_n = 1'b1;
  endtask

  task automatic bwrite(input logic [7:0] d);
    ad_in = d;
    wr_n = 1'b0;
    waitn(3);
    wr_n = 1'b1;
    waitn(4);
  endtask

  task automatic bread(output logic [7:0] d, output logic e);
    ad_in = 8'h00;
    rd_n = 1'b0;
    waitn(4);
    d = ad_out;
    e = oe;
    rd_n = 1'b1;
    waitn(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rdv;
    logic e;
    waitn(3);
    rst = 1'b0;
    waitn(2);
    // R9 reset state
    check("R9 ctl0", c0, 8'h00);
    check("R9 ctl1", c1, 8'h00);
    check("R9 tone", tn, 8'h00);
    check("R9 irq_n", {7'b0, irq_n}, 8'h01);
    check("R9 clk_sel", {7'b0, csel}, 8'h00);
    bread(rdv, e);
    check("R9 R3 no select before latch", {7'b0, e}, 8'h00);

    // R4 R5 vector walk
    foreach (VEC[i]) begin
      latch(VEC[i][18:16], 1'b0);
      bwrite(VEC[i][15:8]);
      latch(VEC[i][18:16], 1'b0);
      bread(rdv, e);
      check($sformatf("R5 R4 vec%0d data", i), rdv, VEC[i][7:0]);
      check($sformatf("R3 vec%0d oe", i), {7'b0, e}, 8'h01);
    end
    check("R10 clk_sel baud", {7'b0, csel}, 8'h01);
    check("R4 ctl1 port", c1, 8'h81);
    check("R4 tone port", tn, 8'hA5);
    check("R3 oe idle", {7'b0, oe}, 8'h00);

    // R1 upper bus bits ignored, cs released after latch
    latch(3'd0, 1'b0);
    bwrite(8'hC3);
    check("R1 write after cs release", c0, 8'hC3);

    // R2 inactive select
    latch(3'd0, 1'b1);
    cs_n = 1'b0;
    bwrite(8'hEE);
    check("R2 write ignored", c0, 8'hC3);
    bread(rdv, e);
    check("R2 no drive", {7'b0, e}, 8'h00);
    cs_n = 1'b1;

    // R6 detect set
    det = 8'h05;
    waitn(1);
    det = 8'h00;
    check("R6 irq low", {7'b0, irq_n}, 8'h00);
    det = 8'h40;
    waitn(1);
    det = 8'h00;
    latch(3'd1, 1'b0);
    bread(rdv, e);
    check("R7 irq kept after other read", {7'b0, irq_n}, 8'h00);
    latch(3'd2, 1'b0);
    bread(rdv, e);
    check("R6 flags sticky", rdv, 8'h45);
    check("R7 irq released", {7'b0, irq_n}, 8'h01);
    bread(rdv, e);
    check("R7 flags cleared", rdv, 8'h00);

    // R8 pulse collides with clear
    det = 8'h03;
    waitn(1);
    det = 8'h00;
    ad_in = 8'h00;
    rd_n = 1'b0;
    waitn(4);
    rd_n = 1'b1;
    waitn(2);
    det = 8'h20;
    waitn(1);
    det = 8'h00;
    waitn(3);
    check("R8 irq stays low", {7'b0, irq_n}, 8'h00);
    bread(rdv, e);
    check("R8 only new flag", rdv, 8'h20);
    check("R8 irq released after reread", {7'b0, irq_n}, 8'h01);

    // R9 reset mid-use
    latch(3'd3, 1'b0);
    bwrite(8'h99);
    det = 8'h01;
    waitn(1);
    det = 8'h00;
    rst = 1'b1;
    waitn(2);
    rst = 1'b0;
    waitn(1);
    check("R9 ctl1 cleared", c1, 8'h00);
    check("R9 tone cleared", tn, 8'h00);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);
    check("R10 clk_sel crystal", {7'b0, csel}, 8'h00);
    bread(rdv, e);
    check("R9 select inactive", {7'b0, e}, 8'h00);
    latch(3'd2, 1'b0);
    bread(rdv, e);
    check("R9 flags cleared", rdv, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule